// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit address space with 16KB pages. It has 64 sets of two ways. A lookup port takes a virtual address, an access type (write, user mode) and the current context identifier. One clock later it reports a hit, a miss or a protection fault, together with the physical address and a cacheable flag. A single segment translation pair, held outside the block and presented on input pins, is compared in parallel with the buffer. It acts as a first-chance mapping that takes precedence over the buffer.

Maintenance uses one shared port with several commands. A fill writes a translation after a miss. A lock pins a resident entry so that replacement never chooses it. An evict removes the entries matching one address, locked or not. Two wide clears discard either the unlocked entries or every entry. Page walking, fault handling and cache control sit outside the block.

Top module: `xlat_buffer`

## Requirements
- R1: After a synchronous active-low reset every entry is empty, rsp_valid and fill_reject are 0, and any lookup misses (rsp_hit=0, rsp_fault=0).
- R2: A lookup accepted on a clock edge is answered on the next edge (rsp_valid=1 for one cycle). The set index is VA[19:14] and the tag is VA[31:20]. A way matches when it is valid, its tag is equal, and either its shared flag is set or its stored context equals ctx_id. If both ways match, way 0 is used.
- R3: A lookup and a maintenance command in the same cycle: the lookup sees the entries as they were before the command.
- R4: A fill writes the lowest way that already matches its address and ctx_id. Otherwise it writes an empty way, way 0 before way 1. Otherwise it writes the way named by a per-set replacement bit. A buffer match on lookup, or a fill, points that bit at the other way. If both happen in the same set in one cycle, the fill decides.
- R5: Replacement never chooses a locked way. If it would have to, the fill is dropped and fill_reject is 1 on the next cycle only. A fill that overwrites a matching entry keeps that entry's lock.
- R6: A lock command sets the lock on every way matching its address and ctx_id. An address with no match changes nothing.
- R7: On a hit, rsp_pa = {PPN, VA[13:0]} and rsp_cacheable is the entry's cacheable flag. Both are 0 when rsp_hit is 0.
- R8: A write to an entry without write permission, or a user access to a supervisor-only entry, gives rsp_fault=1 and rsp_hit=0.
- R9: When seg_enable=1 and VA[31:14] equals seg_vpn, the segment pair supplies the translation and permissions instead of the buffer, and rsp_seg=1. The buffer's replacement bit is still updated by a buffer match.
- R10: An evict command clears every way matching its address and ctx_id, locked or not, and touches no other entry.
- R11: inv_unlocked clears every unlocked entry in one cycle and leaves locked entries intact. inv_everything clears every entry.
- R12: Only one maintenance command acts per cycle, in the priority inv_everything, inv_unlocked, evict, fill, lock. Lower-priority commands in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx_id | input | 8 | Current context identifier |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Lookup virtual address |
| req_write | input | 1 | Lookup is a write |
| req_user | input | 1 | Lookup is a user-mode access |
| seg_enable | input | 1 | Segment pair in use |
| seg_vpn | input | 18 | Segment virtual page number |
| seg_ppn | input | 18 | Segment physical page number |
| seg_cacheable | input | 1 | Segment cacheable flag |
| seg_super_only | input | 1 | Segment supervisor-only flag |
| seg_writable | input | 1 | Segment write permission |
| fill_valid | input | 1 | Fill command |
| fill_va | input | 32 | Fill virtual address |
| fill_ppn | input | 18 | Fill physical page number |
| fill_shared | input | 1 | Fill entry matches any context |
| fill_cacheable | input | 1 | Fill cacheable flag |
| fill_super_only | input | 1 | Fill supervisor-only flag |
| fill_writable | input | 1 | Fill write permission |
| fill_lock | input | 1 | Fill entry is locked on write |
| lock_valid | input | 1 | Lock command |
| lock_va | input | 32 | Lock virtual address |
| evict_valid | input | 1 | Evict command |
| evict_va | input | 32 | Evict virtual address |
| inv_unlocked | input | 1 | Clear all unlocked entries |
| inv_everything | input | 1 | Clear all entries |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Translation found with permission |
| rsp_fault | output | 1 | Translation found, access not permitted |
| rsp_seg | output | 1 | Segment pair matched |
| rsp_pa | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Cacheable flag of the hit |
| fill_reject | output | 1 | Fill dropped, both ways locked |

## Verification
The collisions that matter are a lookup landing in the same cycle as a fill, an evict or a clear of the same page. Several maintenance commands can also be raised together. The bench provokes both in directed steps: a lookup beside an evict of the same address, fill beside evict, and lock beside fill. It then runs a long mixed phase in which every command line is raised independently on a small pool of sets, tags and contexts. Each cycle is judged against a behavioural model that answers the lookup from the pre-update state, then applies only the highest-priority command. This exposes any ordering or replacement-bit disagreement on the next response.

// File: rtl/xlat_pkg.sv
// Package: geometry and entry layout of the translation buffer.
// Assumes a two-way organisation; widths derive from the address,
// page and set sizes below.
package xlat_pkg;
    parameter int VA_W      = 32;
    parameter int PAGE_LOG2 = 14;
    parameter int SET_LOG2  = 6;
    parameter int CTX_W     = 8;

    localparam int SETS  = 1 << SET_LOG2;
    localparam int WAYS  = 2;
    localparam int VPN_W = VA_W - PAGE_LOG2;
    localparam int TAG_W = VPN_W - SET_LOG2;
    localparam int PPN_W = VA_W - PAGE_LOG2;

    typedef struct packed {
        logic             valid;
        logic             locked;
        logic             shared;
        logic             cacheable;
        logic             super_only;
        logic             writable;
        logic [CTX_W-1:0] ctx;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } xlat_entry_t;
endpackage

// File: rtl/xlat_set_match.sv
// Module: compares one set's ways against a tag and context.
// Purely combinational; a way matches when valid, tag equal and
// either shared or context equal. Several ways may match.
module xlat_set_match
    import xlat_pkg::*;
(
    input  xlat_entry_t [WAYS-1:0] ents,
    input  logic [TAG_W-1:0]       tag,
    input  logic [CTX_W-1:0]       ctx,
    output logic [WAYS-1:0]        hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Per-way tag and context comparison.
        assign hit[w] = ents[w].valid && (ents[w].tag == tag) &&
                        (ents[w].shared || (ents[w].ctx == ctx));
    end
endmodule

// File: rtl/xlat_seg_match.sv
// Module: first-chance segment pair comparison.
// Assumes the segment pair maps exactly one page; combinational.
module xlat_seg_match
    import xlat_pkg::*;
(
    input  logic             enable,
    input  logic [VPN_W-1:0] seg_vpn,
    input  logic [VA_W-1:0]  va,
    output logic             hit
);
    // Page-number equality gated by the enable.
    assign hit = enable && (va[VA_W-1 -: VPN_W] == seg_vpn);
endmodule

// File: rtl/xlat_victim.sv
// Module: picks the way a fill writes in a two-way set.
// Order: matching way (lowest), empty way (way 0 first), the way named
// by the replacement bit if unlocked, the other way if unlocked,
// else reject. Assumes WAYS == 2 and that empty ways are unlocked.
module xlat_victim
    import xlat_pkg::*;
(
    input  xlat_entry_t [WAYS-1:0] ents,
    input  logic                   evict_way,
    input  logic [WAYS-1:0]        match,
    output logic                   way,
    output logic                   reject
);
    // Priority selection of the target way.
    always_comb begin
        way    = 1'b0;
        reject = 1'b0;
        if (match[0])                         way = 1'b0;
        else if (match[1])                    way = 1'b1;
        else if (!ents[0].valid)              way = 1'b0;
        else if (!ents[1].valid)              way = 1'b1;
        else if (!ents[evict_way].locked)     way = evict_way;
        else if (!ents[~evict_way].locked)    way = ~evict_way;
        else                                  reject = 1'b1;
    end
endmodule

// File: rtl/xlat_buffer.sv
// Module: 64-set two-way translation buffer with locking, context
// tags and a parallel segment pair. Lookup answers are registered
// (one cycle). One maintenance command acts per cycle, priority:
// inv_everything, inv_unlocked, evict, fill, lock. Lookups observe
// the state before that cycle's command.
module xlat_buffer
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] ctx_id,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             seg_enable,
    input  logic [VPN_W-1:0] seg_vpn,
    input  logic [PPN_W-1:0] seg_ppn,
    input  logic             seg_cacheable,
    input  logic             seg_super_only,
    input  logic             seg_writable,
    input  logic             fill_valid,
    input  logic [VA_W-1:0]  fill_va,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_shared,
    input  logic             fill_cacheable,
    input  logic             fill_super_only,
    input  logic             fill_writable,
    input  logic             fill_lock,
    input  logic             lock_valid,
    input  logic [VA_W-1:0]  lock_va,
    input  logic             evict_valid,
    input  logic [VA_W-1:0]  evict_va,
    input  logic             inv_unlocked,
    input  logic             inv_everything,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic             rsp_seg,
    output logic [VA_W-1:0]  rsp_pa,
    output logic             rsp_cacheable,
    output logic             fill_reject
);
    xlat_entry_t [WAYS-1:0] mem_q [SETS];
    logic                   lru_q [SETS];

    function automatic logic [SET_LOG2-1:0] idx_of(input logic [VA_W-1:0] va);
        return va[PAGE_LOG2 +: SET_LOG2];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: TAG_W];
    endfunction

    // ---------------- lookup path ----------------
    logic [SET_LOG2-1:0]    lk_idx;
    xlat_entry_t [WAYS-1:0] lk_set;
    logic [WAYS-1:0]        lk_hit;
    logic                   lk_way;
    xlat_entry_t            lk_ent;
    logic                   seg_hit;

    assign lk_idx = idx_of(req_va);
    assign lk_set = mem_q[lk_idx];

    xlat_set_match u_lk_match (
        .ents (lk_set),
        .tag  (tag_of(req_va)),
        .ctx  (ctx_id),
        .hit  (lk_hit)
    );

    xlat_seg_match u_seg_match (
        .enable  (seg_enable),
        .seg_vpn (seg_vpn),
        .va      (req_va),
        .hit     (seg_hit)
    );

    assign lk_way = !lk_hit[0];
    assign lk_ent = lk_set[lk_way];

    logic             tr_found;
    logic [PPN_W-1:0] tr_ppn;
    logic             tr_cach;
    logic             tr_super;
    logic             tr_wr;
    logic             tr_bad;

    // Pick the translation source: segment first, then buffer.
    always_comb begin
        tr_found = seg_hit || (|lk_hit);
        tr_ppn   = seg_hit ? seg_ppn        : lk_ent.ppn;
        tr_cach  = seg_hit ? seg_cacheable  : lk_ent.cacheable;
        tr_super = seg_hit ? seg_super_only : lk_ent.super_only;
        tr_wr    = seg_hit ? seg_writable   : lk_ent.writable;
        tr_bad   = (req_write && !tr_wr) || (req_user && tr_super);
    end

    // Register the lookup answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_seg       <= 1'b0;
            rsp_pa        <= '0;
            rsp_cacheable <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_hit       <= req_valid && tr_found && !tr_bad;
            rsp_fault     <= req_valid && tr_found && tr_bad;
            rsp_seg       <= req_valid && seg_hit;
            rsp_pa        <= (req_valid && tr_found && !tr_bad) ?
                             {tr_ppn, req_va[PAGE_LOG2-1:0]} : '0;
            rsp_cacheable <= req_valid && tr_found && !tr_bad && tr_cach;
        end
    end

    // ---------------- maintenance paths ----------------
    logic [SET_LOG2-1:0]    fl_idx, lc_idx, ev_idx;
    xlat_entry_t [WAYS-1:0] fl_set, lc_set, ev_set;
    logic [WAYS-1:0]        fl_hit, lc_hit, ev_hit;
    logic                   fl_way, fl_reject;
    xlat_entry_t            fl_new;

    assign fl_idx = idx_of(fill_va);
    assign lc_idx = idx_of(lock_va);
    assign ev_idx = idx_of(evict_va);
    assign fl_set = mem_q[fl_idx];
    assign lc_set = mem_q[lc_idx];
    assign ev_set = mem_q[ev_idx];

    xlat_set_match u_fl_match (
        .ents (fl_set), .tag (tag_of(fill_va)), .ctx (ctx_id), .hit (fl_hit)
    );
    xlat_set_match u_lc_match (
        .ents (lc_set), .tag (tag_of(lock_va)), .ctx (ctx_id), .hit (lc_hit)
    );
    xlat_set_match u_ev_match (
        .ents (ev_set), .tag (tag_of(evict_va)), .ctx (ctx_id), .hit (ev_hit)
    );

    xlat_victim u_victim (
        .ents      (fl_set),
        .evict_way (lru_q[fl_idx]),
        .match     (fl_hit),
        .way       (fl_way),
        .reject    (fl_reject)
    );

    // Assemble the entry a fill writes; an overwrite keeps its lock.
    always_comb begin
        fl_new            = '0;
        fl_new.valid      = 1'b1;
        fl_new.locked     = fill_lock || ((|fl_hit) && fl_set[fl_way].locked);
        fl_new.shared     = fill_shared;
        fl_new.cacheable  = fill_cacheable;
        fl_new.super_only = fill_super_only;
        fl_new.writable   = fill_writable;
        fl_new.ctx        = ctx_id;
        fl_new.tag        = tag_of(fill_va);
        fl_new.ppn        = fill_ppn;
    end

    logic fill_act;
    assign fill_act = fill_valid && !inv_everything && !inv_unlocked && !evict_valid;

    // Entry storage and replacement bits, one command per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                mem_q[s] <= '0;
                lru_q[s] <= 1'b0;
            end
            fill_reject <= 1'b0;
        end else begin
            fill_reject <= 1'b0;
            if (req_valid && (|lk_hit)) begin
                lru_q[lk_idx] <= ~lk_way;
            end
            if (inv_everything) begin
                for (int s = 0; s < SETS; s++) begin
                    mem_q[s] <= '0;
                end
            end else if (inv_unlocked) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (!mem_q[s][w].locked) mem_q[s][w] <= '0;
                    end
                end
            end else if (evict_valid) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (ev_hit[w]) mem_q[ev_idx][w] <= '0;
                end
            end else if (fill_valid) begin
                if (fl_reject) begin
                    fill_reject <= 1'b1;
                end else begin
                    mem_q[fl_idx][fl_way] <= fl_new;
                    lru_q[fl_idx]         <= ~fl_way;
                end
            end else if (lock_valid) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (lc_hit[w]) mem_q[lc_idx][w].locked <= 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    logic any_valid, any_unlocked_valid;

    // Summaries of storage occupancy for the clear checks.
    always_comb begin
        any_valid          = 1'b0;
        any_unlocked_valid = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (mem_q[s][w].valid) any_valid = 1'b1;
                if (mem_q[s][w].valid && !mem_q[s][w].locked) any_unlocked_valid = 1'b1;
            end
        end
    end

    a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r8_hit_or_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    a_r5_no_locked_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_act && !fl_reject && !(|fl_hit)) |-> !fl_set[fl_way].locked);

    a_r5_reject_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_reject |-> $past(fill_valid));

    a_r11_unlocked_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_unlocked && !inv_everything) |=> !any_unlocked_valid);

    a_r11_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        inv_everything |=> !any_valid);
endmodule

// File: tb/test_xlat_buffer.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios and a mixed random phase.
module test_xlat_buffer;
    import xlat_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic [CTX_W-1:0] ctx_id;
    logic             req_valid, req_write, req_user;
    logic [VA_W-1:0]  req_va;
    logic             seg_enable, seg_cacheable, seg_super_only, seg_writable;
    logic [VPN_W-1:0] seg_vpn;
    logic [PPN_W-1:0] seg_ppn;
    logic             fill_valid, fill_shared, fill_cacheable, fill_super_only;
    logic             fill_writable, fill_lock;
    logic [VA_W-1:0]  fill_va;
    logic [PPN_W-1:0] fill_ppn;
    logic             lock_valid, evict_valid, inv_unlocked, inv_everything;
    logic [VA_W-1:0]  lock_va, evict_va;
    logic             rsp_valid, rsp_hit, rsp_fault, rsp_seg, rsp_cacheable, fill_reject;
    logic [VA_W-1:0]  rsp_pa;

    xlat_buffer i_xlat_buffer (
        .clk, .rst_n, .ctx_id, .req_valid, .req_va, .req_write, .req_user,
        .seg_enable, .seg_vpn, .seg_ppn, .seg_cacheable, .seg_super_only,
        .seg_writable, .fill_valid, .fill_va, .fill_ppn, .fill_shared,
        .fill_cacheable, .fill_super_only, .fill_writable, .fill_lock,
        .lock_valid, .lock_va, .evict_valid, .evict_va, .inv_unlocked,
        .inv_everything, .rsp_valid, .rsp_hit, .rsp_fault, .rsp_seg,
        .rsp_pa, .rsp_cacheable, .fill_reject
    );

    int    checks = 0;
    int    fails  = 0;
    string scen   = "R1 reset";

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL [%s] %s actual=%h expected=%h", scen, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit              mv [SETS][WAYS];
    bit              ml [SETS][WAYS];
    bit              msh[SETS][WAYS];
    bit              mc [SETS][WAYS];
    bit              ms [SETS][WAYS];
    bit              mw [SETS][WAYS];
    bit [CTX_W-1:0]  mctx[SETS][WAYS];
    bit [TAG_W-1:0]  mtag[SETS][WAYS];
    bit [PPN_W-1:0]  mppn[SETS][WAYS];
    bit              mlru[SETS];

    bit              e_valid, e_hit, e_fault, e_seg, e_cach, e_rej;
    bit [VA_W-1:0]   e_pa;

    int              li, lw, fi, fw, ci, vi;
    bit              sg, found, bad, c_c, c_s, c_w, fmatch;
    bit [PPN_W-1:0]  c_p;

    function automatic bit mmatch(input int s, input int w,
                                  input bit [TAG_W-1:0] t, input bit [CTX_W-1:0] c);
        return mv[s][w] && mtag[s][w] == t && (msh[s][w] || mctx[s][w] == c);
    endfunction

    function automatic bit [TAG_W-1:0] tg(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: TAG_W];
    endfunction

    function automatic int ix(input logic [VA_W-1:0] va);
        return int'(va[PAGE_LOG2 +: SET_LOG2]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                mlru[s] = 0;
                for (int w = 0; w < WAYS; w++) begin
                    mv[s][w] = 0; ml[s][w] = 0;
                end
            end
            e_valid = 0; e_hit = 0; e_fault = 0; e_seg = 0; e_cach = 0;
            e_rej = 0; e_pa = '0;
        end else begin
            // Lookup answered from the state before this edge.
            li = ix(req_va);
            lw = -1;
            for (int w = 0; w < WAYS; w++)
                if (lw < 0 && mmatch(li, w, tg(req_va), ctx_id)) lw = w;
            sg = seg_enable && (req_va[VA_W-1 -: VPN_W] == seg_vpn);
            c_p = '0; c_c = 0; c_s = 0; c_w = 0;
            if (sg) begin
                c_p = seg_ppn; c_c = seg_cacheable; c_s = seg_super_only; c_w = seg_writable;
            end else if (lw >= 0) begin
                c_p = mppn[li][lw]; c_c = mc[li][lw]; c_s = ms[li][lw]; c_w = mw[li][lw];
            end
            found   = sg || (lw >= 0);
            bad     = (req_write && !c_w) || (req_user && c_s);
            e_valid = req_valid;
            e_hit   = req_valid && found && !bad;
            e_fault = req_valid && found && bad;
            e_seg   = req_valid && sg;
            e_pa    = e_hit ? {c_p, req_va[PAGE_LOG2-1:0]} : '0;
            e_cach  = e_hit && c_c;
            e_rej   = 0;
            // Fill target from the pre-edge state.
            fi = ix(fill_va);
            fw = -1;
            fmatch = 0;
            for (int w = 0; w < WAYS; w++)
                if (fw < 0 && mmatch(fi, w, tg(fill_va), ctx_id)) begin
                    fw = w; fmatch = 1;
                end
            if (fw < 0) begin
                if (!mv[fi][0])                     fw = 0;
                else if (!mv[fi][1])                fw = 1;
                else if (!ml[fi][mlru[fi]])         fw = int'(mlru[fi]);
                else if (!ml[fi][1 - mlru[fi]])     fw = 1 - int'(mlru[fi]);
            end
            if (req_valid && lw >= 0) mlru[li] = (lw == 0);
            ci = ix(lock_va);
            vi = ix(evict_va);
            if (inv_everything) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++) begin
                        mv[s][w] = 0; ml[s][w] = 0;
                    end
            end else if (inv_unlocked) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        if (!ml[s][w]) mv[s][w] = 0;
            end else if (evict_valid) begin
                for (int w = 0; w < WAYS; w++)
                    if (mmatch(vi, w, tg(evict_va), ctx_id)) begin
                        mv[vi][w] = 0; ml[vi][w] = 0;
                    end
            end else if (fill_valid) begin
                if (fw < 0) e_rej = 1;
                else begin
                    ml[fi][fw]   = fill_lock || (fmatch && ml[fi][fw]);
                    mv[fi][fw]   = 1;
                    msh[fi][fw]  = fill_shared;
                    mc[fi][fw]   = fill_cacheable;
                    ms[fi][fw]   = fill_super_only;
                    mw[fi][fw]   = fill_writable;
                    mctx[fi][fw] = ctx_id;
                    mtag[fi][fw] = tg(fill_va);
                    mppn[fi][fw] = fill_ppn;
                    mlru[fi]     = (fw == 0);
                end
            end else if (lock_valid) begin
                for (int w = 0; w < WAYS; w++)
                    if (mmatch(ci, w, tg(lock_va), ctx_id)) ml[ci][w] = 1;
            end
        end
    end

    // Compare every output against the model away from the edge.
    always @(negedge clk) begin
        chk(rsp_valid === e_valid,     "R2 rsp_valid",     32'(rsp_valid),     32'(e_valid));
        chk(rsp_hit === e_hit,         "R2 rsp_hit",       32'(rsp_hit),       32'(e_hit));
        chk(rsp_fault === e_fault,     "R8 rsp_fault",     32'(rsp_fault),     32'(e_fault));
        chk(rsp_seg === e_seg,         "R9 rsp_seg",       32'(rsp_seg),       32'(e_seg));
        chk(rsp_pa === e_pa,           "R7 rsp_pa",        rsp_pa,             e_pa);
        chk(rsp_cacheable === e_cach,  "R7 rsp_cacheable", 32'(rsp_cacheable), 32'(e_cach));
        chk(fill_reject === e_rej,     "R5 fill_reject",   32'(fill_reject),   32'(e_rej));
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [VA_W-1:0] mkva(input int t, input int i, input int o);
        logic [TAG_W-1:0]     tt = t[TAG_W-1:0];
        logic [SET_LOG2-1:0]  ii = i[SET_LOG2-1:0];
        logic [PAGE_LOG2-1:0] oo = o[PAGE_LOG2-1:0];
        return {tt, ii, oo};
    endfunction

    task automatic clr();
        req_valid = 0; req_va = '0; req_write = 0; req_user = 0;
        fill_valid = 0; fill_va = '0; fill_ppn = '0; fill_shared = 0;
        fill_cacheable = 0; fill_super_only = 0; fill_writable = 0; fill_lock = 0;
        lock_valid = 0; lock_va = '0; evict_valid = 0; evict_va = '0;
        inv_unlocked = 0; inv_everything = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        clr();
    endtask

    task automatic look(input logic [VA_W-1:0] va, input bit wr, input bit usr);
        tick();
        req_valid = 1; req_va = va; req_write = wr; req_user = usr;
    endtask

    task automatic fill(input logic [VA_W-1:0] va, input logic [PPN_W-1:0] ppn,
                        input bit sh, input bit lk, input bit sup, input bit wr);
        tick();
        fill_valid = 1; fill_va = va; fill_ppn = ppn; fill_shared = sh;
        fill_lock = lk; fill_super_only = sup; fill_writable = wr; fill_cacheable = 1;
    endtask

    task automatic lock(input logic [VA_W-1:0] va);
        tick();
        lock_valid = 1; lock_va = va;
    endtask

    task automatic evict(input logic [VA_W-1:0] va);
        tick();
        evict_valid = 1; evict_va = va;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL [watchdog] run did not finish actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; ctx_id = 8'h11;
        seg_enable = 0; seg_vpn = '0; seg_ppn = '0;
        seg_cacheable = 0; seg_super_only = 0; seg_writable = 0;
        clr();
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0 && fill_reject === 1'b0, "R1 outputs idle in reset",
            {30'd0, rsp_valid, fill_reject}, 32'd0);
        rst_n = 1;

        scen = "R1 empty lookup";
        look(mkva(5, 1, 0), 0, 0);
        tick();
        chk(rsp_valid === 1 && rsp_hit === 0, "R1 miss after reset", 32'(rsp_hit), 32'd0);

        scen = "R2 R7 basic fill and hit";
        fill(mkva(5, 1, 0), 18'h2A5A5, 0, 0, 0, 1);
        look(mkva(5, 1, 'h123), 0, 0);
        tick();
        chk(rsp_pa === {18'h2A5A5, 14'h0123}, "R7 physical address", rsp_pa,
            {18'h2A5A5, 14'h0123});

        scen = "R2 context tag and shared";
        ctx_id = 8'h22;
        look(mkva(5, 1, 0), 0, 0);
        fill(mkva(6, 1, 0), 18'h00777, 1, 0, 0, 1);
        tick();
        ctx_id = 8'h11;
        look(mkva(6, 1, 4), 0, 0);
        tick();
        chk(rsp_hit === 1, "R2 shared entry hits other context", 32'(rsp_hit), 32'd1);

        scen = "R3 R10 lookup beside evict";
        tick();
        req_valid = 1; req_va = mkva(5, 1, 8); evict_valid = 1; evict_va = mkva(5, 1, 0);
        look(mkva(5, 1, 8), 0, 0);
        chk(rsp_hit === 1, "R3 lookup sees pre-evict state", 32'(rsp_hit), 32'd1);
        tick();
        chk(rsp_hit === 0, "R10 evicted entry misses", 32'(rsp_hit), 32'd0);

        scen = "R4 replacement order";
        fill(mkva(1, 2, 0), 18'h00101, 0, 0, 0, 1);
        fill(mkva(2, 2, 0), 18'h00102, 0, 0, 0, 1);
        look(mkva(1, 2, 0), 0, 0);
        fill(mkva(3, 2, 0), 18'h00103, 0, 0, 0, 1);
        look(mkva(2, 2, 0), 0, 0);
        look(mkva(1, 2, 0), 0, 0);
        chk(rsp_hit === 0, "R4 least recent way replaced", 32'(rsp_hit), 32'd0);
        tick();
        chk(rsp_hit === 1, "R4 recently used way kept", 32'(rsp_hit), 32'd1);

        scen = "R5 R6 locked set";
        lock(mkva(1, 2, 0));
        lock(mkva(3, 2, 0));
        lock(mkva(9, 2, 0));
        fill(mkva(4, 2, 0), 18'h00104, 0, 0, 0, 1);
        look(mkva(4, 2, 0), 0, 0);
        chk(fill_reject === 1, "R5 fill into locked set rejected", 32'(fill_reject), 32'd1);
        look(mkva(9, 2, 0), 0, 0);
        chk(fill_reject === 0, "R5 reject lasts one cycle", 32'(fill_reject), 32'd0);

        scen = "R10 evict locked entry";
        evict(mkva(1, 2, 0));
        look(mkva(1, 2, 0), 0, 0);
        fill(mkva(4, 2, 0), 18'h00104, 0, 0, 0, 1);
        look(mkva(4, 2, 0), 0, 0);
        tick();
        chk(rsp_hit === 1, "R10 freed way reused", 32'(rsp_hit), 32'd1);

        scen = "R8 protection";
        fill(mkva(1, 3, 0), 18'h00201, 0, 0, 1, 0);
        look(mkva(1, 3, 0), 1, 0);
        look(mkva(1, 3, 0), 0, 1);
        chk(rsp_fault === 1, "R8 write to read-only faults", 32'(rsp_fault), 32'd1);
        look(mkva(1, 3, 0), 0, 0);
        chk(rsp_fault === 1, "R8 user on supervisor page faults", 32'(rsp_fault), 32'd1);
        tick();
        chk(rsp_hit === 1, "R8 supervisor read hits", 32'(rsp_hit), 32'd1);

        scen = "R9 segment pair";
        seg_enable = 1; seg_vpn = mkva(7, 4, 0) >> PAGE_LOG2; seg_ppn = 18'h3FFFF;
        seg_cacheable = 0; seg_writable = 0;
        look(mkva(7, 4, 'h10), 0, 0);
        look(mkva(7, 4, 0), 1, 0);
        chk(rsp_seg === 1 && rsp_pa === {18'h3FFFF, 14'h0010}, "R9 segment translation",
            rsp_pa, {18'h3FFFF, 14'h0010});
        seg_vpn = mkva(1, 3, 0) >> PAGE_LOG2; seg_writable = 1;
        look(mkva(1, 3, 0), 1, 0);
        tick();
        chk(rsp_hit === 1 && rsp_seg === 1, "R9 segment overrides buffer", 32'(rsp_hit), 32'd1);
        seg_enable = 0;

        scen = "R11 wide clears";
        tick();
        inv_unlocked = 1;
        look(mkva(3, 2, 0), 0, 0);
        look(mkva(4, 2, 0), 0, 0);
        chk(rsp_hit === 1, "R11 locked entry survives", 32'(rsp_hit), 32'd1);
        tick();
        inv_everything = 1;
        look(mkva(3, 2, 0), 0, 0);
        tick();
        chk(rsp_hit === 0, "R11 everything cleared", 32'(rsp_hit), 32'd0);

        scen = "R12 command priority";
        fill(mkva(8, 5, 0), 18'h00301, 0, 0, 0, 1);
        tick();
        evict_valid = 1; evict_va = mkva(8, 5, 0);
        fill_valid = 1; fill_va = mkva(8, 5, 0); fill_ppn = 18'h00302; fill_writable = 1;
        look(mkva(8, 5, 0), 0, 0);
        tick();
        chk(rsp_hit === 0, "R12 evict beats fill", 32'(rsp_hit), 32'd0);
        fill_valid = 1; fill_va = mkva(8, 5, 0); fill_ppn = 18'h00303; fill_writable = 1;
        lock_valid = 1; lock_va = mkva(8, 5, 0);
        tick();
        inv_unlocked = 1;
        look(mkva(8, 5, 0), 0, 0);
        tick();
        chk(rsp_hit === 0, "R12 lock beside fill ignored", 32'(rsp_hit), 32'd0);

        scen = "R3 R4 R5 R6 R12 mixed";
        for (int n = 0; n < 4000; n++) begin
            tick();
            ctx_id          = ($urandom % 2 == 0) ? 8'h01 : 8'h02;
            seg_enable      = ($urandom % 8 == 0);
            seg_vpn         = mkva(int'($urandom % 4), 0, 0) >> PAGE_LOG2;
            seg_ppn         = 18'(n);
            seg_writable    = $urandom % 2 == 0;
            req_valid       = $urandom % 4 != 0;
            req_va          = mkva(int'($urandom % 4), int'($urandom % 2), int'($urandom));
            req_write       = $urandom % 3 == 0;
            req_user        = $urandom % 3 == 0;
            fill_valid      = $urandom % 3 == 0;
            fill_va         = mkva(int'($urandom % 4), int'($urandom % 2), 0);
            fill_ppn        = 18'($urandom);
            fill_shared     = $urandom % 4 == 0;
            fill_lock       = $urandom % 5 == 0;
            fill_super_only = $urandom % 4 == 0;
            fill_writable   = $urandom % 4 != 0;
            fill_cacheable  = $urandom % 2 == 0;
            lock_valid      = $urandom % 6 == 0;
            lock_va         = mkva(int'($urandom % 4), int'($urandom % 2), 0);
            evict_valid     = $urandom % 6 == 0;
            evict_va        = mkva(int'($urandom % 4), int'($urandom % 2), 0);
            inv_unlocked    = $urandom % 40 == 0;
            inv_everything  = $urandom % 90 == 0;
        end
        tick();
        tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule